// File: doc/BRIEF.md
# CAN controller global control sequencer

This block holds the global control word of a CAN protocol controller and turns it into the mode signals that the protocol engine and the mailbox array need. Software writes an 8-bit word over a simple byte-wide bus. The block then drives the controller's clock enable, a forced-recessive transmit level, a combined reset, an abort level with a one-cycle mailbox enable-clear pulse, an overload-frame request, a listen-only flag and a timer capture strobe for time-triggered operation.

Some bits clear themselves and others stay set. The general reset bit acts as a pulse and always reads back 0. The overload request stays set until the engine reports that the overload frame has started. The abort request stays set until software clears it. Clearing the enable bit does not stop the controller at once: a frame already on the bus runs to its end first. Setting the enable bit starts the controller after a fixed two-cycle delay.

A write is taken at a rising clock edge while `bus_wr` is high, and the read port shows the new word in the next cycle. Every output comes from a register, or from a register through a single inverter.

Top module: `can_gctl_seq`

## Requirements
- R1: While `rst` is applied and afterwards, until the first write, `bus_rdata` is 0x00, `clk_en` is 0, `tx_force_rec` is 1, and `mbx_en_clr`, `tt_capture`, `ovl_req`, `abort_req` and `listen_en` are 0. `ctl_rst` is 1 in each cycle that follows a clock edge at which `rst` was high.
- R2: The control word is laid out from MSB to LSB as [7] abort, [6] overload request, [5] time-triggered enable, [4] capture select, [3] listen, [2] test, [1] enable, [0] general reset. A write stores bits [7:1], and `bus_rdata` returns them in the next cycle. Bit 0 always reads back as 0.
- R3: A write with bit 0 set clears the whole control word. It also drives `ctl_rst` high for exactly the following cycle and drops `clk_en` to 0 in that same cycle.
- R4: The overload request bit drives `ovl_req`. When `eng_ovl_start` is high at an edge with no write, the bit reads 0 after that edge. If a write happens at the same edge, the written value wins.
- R5: The abort bit drives `abort_req` and holds its value until it is written again. `mbx_en_clr` is high for exactly one cycle: the cycle that follows the first cycle in which the abort bit reads 1. Writing 1 again while the bit is already 1 gives no further pulse.
- R6: After a write sets the enable bit, `clk_en` stays 0 for one more cycle and goes to 1 two cycles after the write edge.
- R7: Once `clk_en` is 1, it stays 1 at every edge where the enable bit is 1 or `eng_busy` is high. It drops to 0 after the first edge at which both are low.
- R8: `tx_force_rec` is always the inverse of `clk_en`.
- R9: With the time-triggered enable bit set, `tt_capture` pulses in the cycle after `eng_sof` when the capture select bit is 0, and in the cycle after `eng_eof_last` when the select bit is 1. The strobe that is not selected has no effect.
- R10: With the time-triggered enable bit clear, `tt_capture` stays 0 whatever the frame strobes do.
- R11: `listen_en` follows bit 3 of the control word.
- R12: The test bit (bit 2) reads back as written and has no effect on any other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_wr | input | 1 | Write strobe for the control word |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Current control word |
| eng_busy | input | 1 | A frame is in progress on the bus |
| eng_sof | input | 1 | Start-of-frame strobe |
| eng_eof_last | input | 1 | Last bit of end-of-frame strobe |
| eng_ovl_start | input | 1 | Overload frame transmission has begun |
| mbx_en_clr | output | 1 | One-cycle pulse that clears every mailbox enable flag |
| ctl_rst | output | 1 | Combined hardware and software reset for the controller |
| clk_en | output | 1 | Controller clock enable (running) |
| tx_force_rec | output | 1 | Hold the transmit line recessive |
| tt_capture | output | 1 | Timer capture strobe |
| ovl_req | output | 1 | Overload frame request to the engine |
| abort_req | output | 1 | Abort pending transmissions |
| listen_en | output | 1 | Listen-only mode |

## Verification
Directed sequences cover the corner cases that separate the bit behaviours:
- Disabling while `eng_busy` is high separates an immediate stop from a deferred one.
- A repeated abort write separates edge-triggered pulsing from level-triggered pulsing.
- An overload start strobe separates the self-clearing bit from sticky bits.
- Sending both frame strobes under each capture select, and under time-triggered off, shows which strobe is routed and when gating applies.

Long random runs mix sparse writes, rare general resets and hardware resets with random busy periods and frame strobes. They compare every output each cycle against a cycle model in the bench. This catches interactions such as a write that lands on the same edge as an overload start, or a re-enable during the wind-down of a frame.

// File: rtl/canctl_pkg.sv
package canctl_pkg;
  typedef struct packed {
    logic abort;
    logic ovl;
    logic tt_en;
    logic tt_sync;
    logic listen;
    logic test;
    logic enable;
    logic grst;
  } ctl_word_t;

  localparam int CTL_W = $bits(ctl_word_t);
endpackage

// File: rtl/cc_ctlreg.sv
module cc_ctlreg
  import canctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr,
  input  ctl_word_t wdata,
  input  logic      ovl_start,
  output ctl_word_t ctl,
  output logic      reset_now,
  output logic      ctl_rst
);
  assign reset_now = rst | (wr & wdata.grst);

  always_ff @(posedge clk) begin
    if (reset_now) begin
      ctl <= '0;
    end else if (wr) begin
      ctl      <= wdata;
      ctl.grst <= 1'b0;
    end else if (ovl_start) begin
      ctl.ovl <= 1'b0;
    end
  end

  always_ff @(posedge clk) ctl_rst <= reset_now;

  // R3
  grst_selfclr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && wdata.grst) |=> (ctl_rst && ctl == '0));
  // R4
  ovl_hwclr_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr && ovl_start) |=> !ctl.ovl);
  // R5
  abort_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.abort && !wr) |=> ctl.abort);
endmodule

// File: rtl/cc_runseq.sv
module cc_runseq #(
  parameter int START_DLY = 2
) (
  input  logic clk,
  input  logic reset_now,
  input  logic en,
  input  logic busy,
  output logic run
);
  localparam int CW = $clog2(START_DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(START_DLY - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (reset_now) begin
      cnt <= '0;
      run <= 1'b0;
    end else begin
      if (!en)
        cnt <= '0;
      else if (cnt != LAST)
        cnt <= cnt + 1'b1;
      if (en && cnt == LAST)
        run <= 1'b1;
      else if (!en && !busy)
        run <= 1'b0;
    end
  end

  // R6
  start_delay_chk: assert property (@(posedge clk) disable iff (reset_now)
    $rose(run) |-> ($past(en) && $past(en, 2)));
  // R7
  stop_wait_chk: assert property (@(posedge clk) disable iff (reset_now)
    $fell(run) |-> ($past(!en && !busy) || $past(reset_now)));
endmodule

// File: rtl/cc_evtgen.sv
module cc_evtgen (
  input  logic clk,
  input  logic reset_now,
  input  logic abort,
  input  logic tt_en,
  input  logic tt_sync,
  input  logic sof,
  input  logic eof_last,
  output logic mbx_clr,
  output logic cap
);
  logic abt_prev;

  always_ff @(posedge clk) begin
    if (reset_now) begin
      abt_prev <= 1'b0;
      mbx_clr  <= 1'b0;
      cap      <= 1'b0;
    end else begin
      abt_prev <= abort;
      mbx_clr  <= abort & ~abt_prev;
      cap      <= tt_en & (tt_sync ? eof_last : sof);
    end
  end

  // R5
  clr_pulse_chk: assert property (@(posedge clk) disable iff (reset_now)
    mbx_clr |=> !mbx_clr);
  // R10
  cap_gate_chk: assert property (@(posedge clk) disable iff (reset_now)
    cap |-> $past(tt_en));
  // R9
  cap_sel_chk: assert property (@(posedge clk) disable iff (reset_now)
    cap |-> $past(tt_sync ? eof_last : sof));
endmodule

// File: rtl/can_gctl_seq.sv
module can_gctl_seq
  import canctl_pkg::*;
#(
  parameter int START_DLY = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic [CTL_W-1:0] bus_wdata,
  output logic [CTL_W-1:0] bus_rdata,
  input  logic             eng_busy,
  input  logic             eng_sof,
  input  logic             eng_eof_last,
  input  logic             eng_ovl_start,
  output logic             mbx_en_clr,
  output logic             ctl_rst,
  output logic             clk_en,
  output logic             tx_force_rec,
  output logic             tt_capture,
  output logic             ovl_req,
  output logic             abort_req,
  output logic             listen_en
);
  ctl_word_t ctl;
  logic      reset_now;
  logic      run;

  cc_ctlreg u_reg (
    .clk       (clk),
    .rst       (rst),
    .wr        (bus_wr),
    .wdata     (ctl_word_t'(bus_wdata)),
    .ovl_start (eng_ovl_start),
    .ctl       (ctl),
    .reset_now (reset_now),
    .ctl_rst   (ctl_rst)
  );

  cc_runseq #(.START_DLY(START_DLY)) u_run (
    .clk       (clk),
    .reset_now (reset_now),
    .en        (ctl.enable),
    .busy      (eng_busy),
    .run       (run)
  );

  cc_evtgen u_evt (
    .clk       (clk),
    .reset_now (reset_now),
    .abort     (ctl.abort),
    .tt_en     (ctl.tt_en),
    .tt_sync   (ctl.tt_sync),
    .sof       (eng_sof),
    .eof_last  (eng_eof_last),
    .mbx_clr   (mbx_en_clr),
    .cap       (tt_capture)
  );

  assign bus_rdata    = ctl;
  assign clk_en       = run;
  assign tx_force_rec = ~run;
  assign ovl_req      = ctl.ovl;
  assign abort_req    = ctl.abort;
  assign listen_en    = ctl.listen;

  // R8
  rec_inv_chk: assert property (@(posedge clk) disable iff (rst)
    tx_force_rec != clk_en);
  // R2
  grst_rd0_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> (bus_rdata[0] == 1'b0));
endmodule

// File: tb/sim_can_gctl_seq.sv
module sim_can_gctl_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       eng_busy = 1'b0, eng_sof = 1'b0, eng_eof_last = 1'b0, eng_ovl_start = 1'b0;
  logic       mbx_en_clr, ctl_rst, clk_en, tx_force_rec, tt_capture;
  logic       ovl_req, abort_req, listen_en;

  int total = 0;
  int bad = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  can_gctl_seq u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_busy(eng_busy), .eng_sof(eng_sof), .eng_eof_last(eng_eof_last),
    .eng_ovl_start(eng_ovl_start), .mbx_en_clr(mbx_en_clr), .ctl_rst(ctl_rst),
    .clk_en(clk_en), .tx_force_rec(tx_force_rec), .tt_capture(tt_capture),
    .ovl_req(ovl_req), .abort_req(abort_req), .listen_en(listen_en)
  );

  // cycle model built from the requirements
  logic [7:0] m_reg = 8'h00;
  logic       m_rst = 1'b0, m_run = 1'b0, m_prev = 1'b0, m_clr = 1'b0, m_cap = 1'b0;
  int         m_encyc = 0;

  function automatic logic m_reset_now(logic r, logic w, logic [7:0] d);
    return r | (w & d[0]);
  endfunction

  function automatic logic m_cap_next(logic [7:0] c, logic s, logic e);
    if (!c[5]) return 1'b0;
    return c[4] ? e : s;
  endfunction

  always @(posedge clk) begin
    logic rn;
    rn = m_reset_now(rst, bus_wr, bus_wdata);
    m_rst <= rn;
    if (rn) begin
      m_reg <= 8'h00; m_run <= 1'b0; m_encyc <= 0;
      m_prev <= 1'b0; m_clr <= 1'b0; m_cap <= 1'b0;
    end else begin
      if (bus_wr) m_reg <= {bus_wdata[7:1], 1'b0};
      else if (eng_ovl_start) m_reg[6] <= 1'b0;
      m_encyc <= m_reg[1] ? m_encyc + 1 : 0;
      if (m_reg[1] && m_encyc >= 1) m_run <= 1'b1;
      else if (!m_reg[1] && !eng_busy) m_run <= 1'b0;
      m_prev <= m_reg[7];
      m_clr  <= m_reg[7] & ~m_prev;
      m_cap  <= m_cap_next(m_reg, eng_sof, eng_eof_last);
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2 readback", bus_rdata, m_reg);
      chk("R3 ctl_rst", {7'd0, ctl_rst}, {7'd0, m_rst});
      chk("R4 ovl_req", {7'd0, ovl_req}, {7'd0, m_reg[6]});
      chk("R5 abort_req", {7'd0, abort_req}, {7'd0, m_reg[7]});
      chk("R5 mbx_en_clr", {7'd0, mbx_en_clr}, {7'd0, m_clr});
      chk("R7 clk_en", {7'd0, clk_en}, {7'd0, m_run});
      chk("R8 tx_force_rec", {7'd0, tx_force_rec}, {7'd0, ~m_run});
      chk("R9 tt_capture", {7'd0, tt_capture}, {7'd0, m_cap});
      chk("R11 listen_en", {7'd0, listen_en}, {7'd0, m_reg[3]});
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    tick(3);
    // R1 reset state
    chk("R1 rdata", bus_rdata, 8'h00);
    chk("R1 clk_en", {7'd0, clk_en}, 8'h00);
    chk("R1 tx_force_rec", {7'd0, tx_force_rec}, 8'h01);
    chk("R1 outs", {3'd0, mbx_en_clr, tt_capture, ovl_req, abort_req, listen_en}, 8'h00);
    chk("R1 ctl_rst", {7'd0, ctl_rst}, 8'h01);
    rst = 1'b0;
    tick();
    chk("R1 ctl_rst off", {7'd0, ctl_rst}, 8'h00);

    // R6 start delay
    wr_ctl(8'h02);
    chk("R6 clk_en +0", {7'd0, clk_en}, 8'h00);
    tick();
    chk("R6 clk_en +1", {7'd0, clk_en}, 8'h00);
    tick();
    chk("R6 clk_en +2", {7'd0, clk_en}, 8'h01);
    chk("R8 rec low", {7'd0, tx_force_rec}, 8'h00);

    // R7 stop waits for frame end
    eng_busy = 1'b1;
    wr_ctl(8'h00);
    tick(2);
    chk("R7 held while busy", {7'd0, clk_en}, 8'h01);
    eng_busy = 1'b0;
    tick();
    chk("R7 stopped", {7'd0, clk_en}, 8'h00);
    chk("R8 rec high", {7'd0, tx_force_rec}, 8'h01);

    // R5 abort pulse and stickiness
    wr_ctl(8'h80);
    chk("R5 no pulse yet", {7'd0, mbx_en_clr}, 8'h00);
    chk("R5 abort_req", {7'd0, abort_req}, 8'h01);
    tick();
    chk("R5 pulse", {7'd0, mbx_en_clr}, 8'h01);
    tick();
    chk("R5 pulse end", {7'd0, mbx_en_clr}, 8'h00);
    wr_ctl(8'h80);
    tick();
    chk("R5 no repeat", {7'd0, mbx_en_clr}, 8'h00);
    tick(3);
    chk("R5 sticky", bus_rdata, 8'h80);
    wr_ctl(8'h00);

    // R4 overload self clear
    wr_ctl(8'h40);
    tick(3);
    chk("R4 ovl held", {7'd0, ovl_req}, 8'h01);
    eng_ovl_start = 1'b1;
    tick();
    eng_ovl_start = 1'b0;
    chk("R4 ovl cleared", bus_rdata, 8'h00);

    // R3 general reset
    wr_ctl(8'h0E);
    tick(3);
    chk("R3 pre running", {7'd0, clk_en}, 8'h01);
    wr_ctl(8'h0F);
    chk("R3 ctl_rst", {7'd0, ctl_rst}, 8'h01);
    chk("R3 cleared", bus_rdata, 8'h00);
    chk("R3 disabled", {7'd0, clk_en}, 8'h00);
    tick();
    chk("R3 ctl_rst pulse", {7'd0, ctl_rst}, 8'h00);

    // R12 test bit no effect, R11 listen
    wr_ctl(8'h04);
    tick(3);
    chk("R12 readback", bus_rdata, 8'h04);
    chk("R12 outs", {2'd0, clk_en, mbx_en_clr, tt_capture, ovl_req, abort_req, listen_en}, 8'h00);
    wr_ctl(8'h08);
    chk("R11 listen", {7'd0, listen_en}, 8'h01);

    // R9 capture select
    wr_ctl(8'h20);
    eng_sof = 1'b1; tick(); eng_sof = 1'b0;
    chk("R9 sof capture", {7'd0, tt_capture}, 8'h01);
    tick();
    chk("R9 capture pulse", {7'd0, tt_capture}, 8'h00);
    eng_eof_last = 1'b1; tick(); eng_eof_last = 1'b0;
    chk("R9 eof ignored", {7'd0, tt_capture}, 8'h00);
    wr_ctl(8'h30);
    eng_eof_last = 1'b1; tick(); eng_eof_last = 1'b0;
    chk("R9 eof capture", {7'd0, tt_capture}, 8'h01);
    eng_sof = 1'b1; tick(); eng_sof = 1'b0;
    chk("R9 sof ignored", {7'd0, tt_capture}, 8'h00);
    // R10 gated off
    wr_ctl(8'h10);
    eng_sof = 1'b1; eng_eof_last = 1'b1; tick(); eng_sof = 1'b0; eng_eof_last = 1'b0;
    chk("R10 off", {7'd0, tt_capture}, 8'h00);

    // random phase against the model
    cmp_on = 1'b1;
    for (int c = 0; c < 4000; c++) begin
      logic [7:0] d;
      d = 8'($urandom);
      if (($urandom % 16) != 0) d[0] = 1'b0;
      rst           = (($urandom % 700) == 0);
      bus_wr        = (($urandom % 6) == 0);
      bus_wdata     = d;
      if (($urandom % 5) == 0) eng_busy = ~eng_busy;
      eng_sof       = (($urandom % 7) == 0);
      eng_eof_last  = (($urandom % 7) == 0);
      eng_ovl_start = (($urandom % 9) == 0);
      tick();
    end
    rst = 1'b0; bus_wr = 1'b0; eng_sof = 1'b0; eng_eof_last = 1'b0; eng_ovl_start = 1'b0;
    tick(2);
    cmp_on = 1'b0;
    finish_run();
  end
endmodule